// File: doc/BRIEF.md
# Banked Internal Data Memory with Hardware Stack

This block is the 128-byte on-chip data store of a small 8-bit controller core. The lowest 32 bytes hold four banks of eight working registers, a 2-bit bank-select input chooses which bank the register numbers reach, and a 16-byte window above them can be set, cleared and tested one bit at a time. The remaining bytes are free scratch space. An 8-bit stack pointer lives beside the array and moves on push and pop.

The core issues one operation per clock on a 4-bit operation input. Register, direct, indirect, bit and stack operations all resolve to a single byte location in the same cycle. Read results and bit results appear on registered outputs one clock later. Writes land at the same clock edge. A read always sees the contents from before that edge.

The design has no state machine. Each operation completes in the cycle it is issued, so the only sequential state is the byte array, the stack pointer and the two result registers. Operations are decoded with a unique case over an enumerated operation type.

Top module: `iram_bank_stack`

## Requirements
- R1: A register operation with bank select b (0..3) and register number r (0..7) reaches byte 8*b + r. Bank 0 covers bytes 0x00-0x07, bank 1 covers 0x08-0x0F, bank 2 covers 0x10-0x17 and bank 3 covers 0x18-0x1F.
- R2: Direct operations reach any byte 0..127 by `addr`. Direct addresses 0..7 are the same storage as bank-0 registers 0..7. Writes take effect at the clock edge of the operation.
- R3: Bit address n (0..127, on `addr`) selects bit n mod 8 of byte 0x20 + n/8. Bit set and bit clear change only that bit. Bit read, bit set and bit clear all return on `rbit`, one clock later, the value the bit held before the operation.
- R4: An indirect operation takes its 8-bit pointer from R0 (`reg_num[0]`=0) or R1 (`reg_num[0]`=1) of the selected bank. A pointer of 0x80 or above drops the write and makes the read return 0.
- R5: During reset the stack pointer becomes 0x07, every byte becomes 0, and `rdata` and `rbit` become 0.
- R6: A push first adds 1 to the stack pointer and then writes `wdata` at the new pointer. Three pushes from reset therefore land at 0x08, 0x09 and 0x0A. If the new pointer is 0x80 or above, the write is dropped.
- R7: A pop returns the byte at the current stack pointer (0 if the pointer is 0x80 or above) and then subtracts 1 from the pointer. The pointer wraps modulo 256.
- R8: `rdata` is updated one clock after a register read, direct read, indirect read or pop, and holds for every other operation. A read result is always the value from before any write at that edge.
- R9: The operation codes are: 0 nop, 1 register read, 2 register write, 3 direct read, 4 direct write, 5 indirect read, 6 indirect write, 7 bit read, 8 bit set, 9 bit clear, 10 push, 11 pop. Codes 12-15 act as nop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 4 | Operation code for this cycle |
| bank_sel | input | 2 | Active register bank |
| reg_num | input | 3 | Working register number; bit 0 picks the pointer register for indirect operations |
| addr | input | 7 | Direct byte address or bit address |
| wdata | input | 8 | Write and push data |
| rdata | output | 8 | Registered read and pop result |
| rbit | output | 1 | Registered prior value of the addressed bit |
| sp | output | 8 | Current stack pointer |

## Verification
The bench builds the block with its default parameters: 8-bit data, a 7-bit byte address, a stack pointer reset of 0x07 and a bit window at 0x20. With these values, a few hundred pushes drive the 8-bit pointer past 0x7F and around through 0xFF to 0x00. The bench can therefore reach dropped writes and zero reads for stack and indirect accesses above the array. A behavioural model follows every operation, including long random streams that mix all codes and banks.

// File: rtl/iram_pkg.sv
package iram_pkg;

    typedef enum logic [3:0] {
        OP_NOP     = 4'd0,
        OP_RD_REG  = 4'd1,
        OP_WR_REG  = 4'd2,
        OP_RD_DIR  = 4'd3,
        OP_WR_DIR  = 4'd4,
        OP_RD_IND  = 4'd5,
        OP_WR_IND  = 4'd6,
        OP_BIT_RD  = 4'd7,
        OP_BIT_SET = 4'd8,
        OP_BIT_CLR = 4'd9,
        OP_PUSH    = 4'd10,
        OP_POP     = 4'd11
    } iram_op_e;

    function automatic logic op_reads_byte(input iram_op_e o);
        return (o == OP_RD_REG) || (o == OP_RD_DIR) ||
               (o == OP_RD_IND) || (o == OP_POP);
    endfunction

    function automatic logic op_is_bit(input iram_op_e o);
        return (o == OP_BIT_RD) || (o == OP_BIT_SET) || (o == OP_BIT_CLR);
    endfunction

endpackage

// File: rtl/iram_store.sv
module iram_store #(
    parameter int DATA_W = 8,
    parameter int AW     = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wbyte,
    input  logic [AW-1:0]     rd_addr,
    input  logic [AW-1:0]     ptr_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] ptr_data
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem [DEPTH];

    assign rd_data  = mem[rd_addr];
    assign ptr_data = mem[ptr_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wbyte;
        end
    end

    // R2: a write is visible at its location on the following cycle
    p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
        we |=> (mem[$past(waddr)] == $past(wbyte)));

endmodule

// File: rtl/iram_addr_map.sv
module iram_addr_map
    import iram_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int AW       = 7,
    parameter int BANK_W   = 2,
    parameter int REG_W    = 3,
    parameter int BIT_BASE = 32
) (
    input  iram_op_e          op,
    input  logic [BANK_W-1:0] bank,
    input  logic [REG_W-1:0]  reg_num,
    input  logic [AW-1:0]     dir_addr,
    input  logic [DATA_W-1:0] ptr_val,
    input  logic [AW:0]       sp,
    output logic [AW-1:0]     ptr_addr,
    output logic [AW:0]       eff_addr,
    output logic [2:0]        bit_idx
);
    localparam int EW = AW + 1;
    localparam int RW = BANK_W + REG_W;
    localparam logic [EW-1:0] BASE     = EW'(BIT_BASE);
    localparam logic [EW-1:0] BIT_SPAN = EW'(1 << (AW - 3));

    logic [RW-1:0] reg_loc;
    logic [RW-1:0] ptr_loc;

    assign reg_loc  = {bank, reg_num};
    assign ptr_loc  = {bank, {(REG_W-1){1'b0}}, reg_num[0]};
    assign ptr_addr = {{(AW-RW){1'b0}}, ptr_loc};
    assign bit_idx  = dir_addr[2:0];

    always_comb begin
        unique case (op)
            OP_RD_REG, OP_WR_REG:              eff_addr = {{(EW-RW){1'b0}}, reg_loc};
            OP_RD_DIR, OP_WR_DIR:              eff_addr = {1'b0, dir_addr};
            OP_RD_IND, OP_WR_IND:              eff_addr = EW'(ptr_val);
            OP_BIT_RD, OP_BIT_SET, OP_BIT_CLR: eff_addr = BASE + EW'(dir_addr[AW-1:3]);
            OP_PUSH:                           eff_addr = sp + 1'b1;
            OP_POP:                            eff_addr = sp;
            default:                           eff_addr = '0;
        endcase
    end

    always_comb begin
        if (op == OP_RD_REG || op == OP_WR_REG) begin
            p_bank_region_r1: assert (eff_addr < EW'(1 << RW));
        end
        if (op_is_bit(op)) begin
            p_bit_window_r3: assert (eff_addr >= BASE && eff_addr < BASE + BIT_SPAN);
        end
    end

endmodule

// File: rtl/iram_sp.sv
module iram_sp #(
    parameter int EW     = 8,
    parameter int SP_RST = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    output logic [EW-1:0] sp
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sp <= EW'(SP_RST);
        end else if (push) begin
            sp <= sp + 1'b1;
        end else if (pop) begin
            sp <= sp - 1'b1;
        end
    end

    p_push_inc_r6: assert property (@(posedge clk) disable iff (rst)
        push |=> (sp == $past(sp) + 1'b1));

    p_pop_dec_r7: assert property (@(posedge clk) disable iff (rst)
        (pop && !push) |=> (sp == $past(sp) - 1'b1));

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!pop && !push) |=> $stable(sp));

endmodule

// File: rtl/iram_bank_stack.sv
module iram_bank_stack
    import iram_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int AW       = 7,
    parameter int BANK_W   = 2,
    parameter int REG_W    = 3,
    parameter int BIT_BASE = 32,
    parameter int SP_RST   = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        op,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic [REG_W-1:0]  reg_num,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rbit,
    output logic [AW:0]       sp
);
    localparam int EW = AW + 1;

    iram_op_e          op_e;
    logic [AW-1:0]     ptr_addr;
    logic [DATA_W-1:0] ptr_data;
    logic [EW-1:0]     eff_addr;
    logic [2:0]        bit_idx;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] bit_mask;
    logic              in_range;
    logic              we;
    logic [DATA_W-1:0] wbyte;

    assign op_e     = iram_op_e'(op);
    assign in_range = !eff_addr[EW-1];
    assign bit_mask = DATA_W'(1) << bit_idx;

    iram_addr_map #(
        .DATA_W(DATA_W), .AW(AW), .BANK_W(BANK_W),
        .REG_W(REG_W), .BIT_BASE(BIT_BASE)
    ) u_map (
        .op(op_e), .bank(bank_sel), .reg_num(reg_num), .dir_addr(addr),
        .ptr_val(ptr_data), .sp(sp), .ptr_addr(ptr_addr),
        .eff_addr(eff_addr), .bit_idx(bit_idx)
    );

    iram_store #(.DATA_W(DATA_W), .AW(AW)) u_store (
        .clk(clk), .rst(rst), .we(we), .waddr(eff_addr[AW-1:0]),
        .wbyte(wbyte), .rd_addr(eff_addr[AW-1:0]), .ptr_addr(ptr_addr),
        .rd_data(rd_data), .ptr_data(ptr_data)
    );

    iram_sp #(.EW(EW), .SP_RST(SP_RST)) u_sp (
        .clk(clk), .rst(rst), .push(op_e == OP_PUSH),
        .pop(op_e == OP_POP), .sp(sp)
    );

    always_comb begin
        we    = 1'b0;
        wbyte = wdata;
        unique case (op_e)
            OP_WR_REG, OP_WR_DIR: we = 1'b1;
            OP_WR_IND, OP_PUSH:   we = in_range;
            OP_BIT_SET: begin
                we    = 1'b1;
                wbyte = rd_data | bit_mask;
            end
            OP_BIT_CLR: begin
                we    = 1'b1;
                wbyte = rd_data & ~bit_mask;
            end
            default: we = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            rbit  <= 1'b0;
        end else begin
            if (op_reads_byte(op_e)) begin
                rdata <= in_range ? rd_data : '0;
            end
            if (op_is_bit(op_e)) begin
                rbit <= rd_data[bit_idx];
            end
        end
    end

    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !op_reads_byte(op_e) |=> $stable(rdata));

    p_oor_read_zero_r4: assert property (@(posedge clk) disable iff (rst)
        ((op_e == OP_RD_IND || op_e == OP_POP) && !in_range) |=> (rdata == '0));

    p_rbit_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !op_is_bit(op_e) |=> $stable(rbit));

endmodule

// File: tb/test_iram_bank_stack.sv
`timescale 1ns/1ps
module test_iram_bank_stack;

    localparam int K_NOP = 0, K_RDR = 1, K_WRR = 2, K_RDD = 3, K_WRD = 4,
                   K_RDI = 5, K_WRI = 6, K_BRD = 7, K_BST = 8, K_BCL = 9,
                   K_PSH = 10, K_POP = 11;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op = '0;
    logic [1:0] bank_sel = '0;
    logic [2:0] reg_num = '0;
    logic [6:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rbit;
    logic [7:0] sp;

    int checks = 0;
    int fails  = 0;

    int mem [128];
    int m_sp, m_rdata, m_rbit;

    iram_bank_stack i_iram_bank_stack (
        .clk(clk), .rst(rst), .op(op), .bank_sel(bank_sel), .reg_num(reg_num),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rbit(rbit), .sp(sp)
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model(input int o, input int b, input int r, input int a, input int d);
        int loc, p, bi;
        case (o)
            K_RDR: m_rdata = mem[b*8 + r];
            K_WRR: mem[b*8 + r] = d;
            K_RDD: m_rdata = mem[a];
            K_WRD: mem[a] = d;
            K_RDI, K_WRI: begin
                p = mem[b*8 + (r % 2)];
                if (o == K_RDI) m_rdata = (p < 128) ? mem[p] : 0;
                else if (p < 128) mem[p] = d;
            end
            K_BRD, K_BST, K_BCL: begin
                loc = 32 + a / 8;
                bi  = a % 8;
                m_rbit = (mem[loc] >> bi) & 1;
                if (o == K_BST) mem[loc] = mem[loc] | (1 << bi);
                if (o == K_BCL) mem[loc] = mem[loc] & ~(1 << bi) & 255;
            end
            K_PSH: begin
                m_sp = (m_sp + 1) % 256;
                if (m_sp < 128) mem[m_sp] = d;
            end
            K_POP: begin
                m_rdata = (m_sp < 128) ? mem[m_sp] : 0;
                m_sp = (m_sp + 255) % 256;
            end
            default: ;
        endcase
    endtask

    task automatic step(input string tag, input int o, input int b, input int r,
                        input int a, input int d);
        op = 4'(o); bank_sel = 2'(b); reg_num = 3'(r); addr = 7'(a); wdata = 8'(d);
        @(posedge clk);
        model(o, b, r, a, d);
        @(negedge clk);
        check({tag, " rdata"}, int'(rdata), m_rdata);
        check({tag, " rbit"}, int'(rbit), m_rbit);
        check({tag, " sp"}, int'(sp), m_sp);
    endtask

    task automatic rd_dir(input string tag, input int a, input int exp);
        step(tag, K_RDD, 0, 0, a, 0);
        check({tag, " literal"}, int'(rdata), exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        foreach (mem[i]) mem[i] = 0;
        m_sp = 7; m_rdata = 0; m_rbit = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R5: reset state
        check("R5 sp reset", int'(sp), 7);
        check("R5 rdata reset", int'(rdata), 0);
        check("R5 rbit reset", int'(rbit), 0);
        for (int i = 0; i < 128; i++) rd_dir("R5 cleared", i, 0);

        // R1: each bank reaches its own 8 bytes
        for (int b = 0; b < 4; b++)
            for (int r = 0; r < 8; r++) step("R1 wr", K_WRR, b, r, 0, 16*b + r + 1);
        rd_dir("R1 bank2 r5", 8'h15, 16*2 + 5 + 1);
        rd_dir("R1 bank3 r7", 8'h1F, 16*3 + 7 + 1);
        step("R1 rd", K_RDR, 1, 3, 0, 0);
        check("R1 bank1 r3", int'(rdata), 16 + 3 + 1);

        // R2: direct 0..7 alias bank-0 registers
        step("R2 wr", K_WRD, 0, 0, 6, 8'hA5);
        step("R2 rd", K_RDR, 0, 6, 0, 0);
        check("R2 alias", int'(rdata), 8'hA5);
        step("R2 scratch", K_WRD, 0, 0, 8'h7F, 8'h3C);
        rd_dir("R2 top", 8'h7F, 8'h3C);

        // R3: bit window
        step("R3 set5", K_BST, 0, 0, 5, 0);
        check("R3 old bit", int'(rbit), 0);
        rd_dir("R3 byte20", 8'h20, 8'h20);
        step("R3 set127", K_BST, 0, 0, 127, 0);
        rd_dir("R3 byte2F", 8'h2F, 8'h80);
        step("R3 rd5", K_BRD, 0, 0, 5, 0);
        check("R3 bit5", int'(rbit), 1);
        step("R3 wr21", K_WRD, 0, 0, 8'h21, 8'hFF);
        step("R3 clr10", K_BCL, 0, 0, 10, 0);
        check("R3 clr old", int'(rbit), 1);
        rd_dir("R3 byte21", 8'h21, 8'hFB);

        // R4: indirect through R0/R1 of the active bank
        step("R4 ptr", K_WRR, 2, 0, 0, 8'h45);
        step("R4 ptr1", K_WRR, 2, 1, 0, 8'h90);
        step("R4 wr", K_WRI, 2, 0, 0, 8'h77);
        rd_dir("R4 land", 8'h45, 8'h77);
        step("R4 rd", K_RDI, 2, 2, 0, 0);
        check("R4 via R0", int'(rdata), 8'h77);
        step("R4 oor wr", K_WRI, 2, 1, 0, 8'h55);
        step("R4 oor rd", K_RDI, 2, 1, 0, 0);
        check("R4 oor zero", int'(rdata), 0);
        rd_dir("R4 no alias", 8'h10, 8'h90 & 8'h00 | 8'h45);

        // R8: hold on non-read ops
        step("R8 nop", K_NOP, 0, 0, 0, 0);
        check("R8 hold", int'(rdata), 8'h45);
        step("R8 code15", 15, 0, 0, 0, 8'hEE);
        check("R8 hold15", int'(rdata), 8'h45);

        // R6 / R7: stack from reset
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        foreach (mem[i]) mem[i] = 0;
        m_sp = 7; m_rdata = 0; m_rbit = 0;
        step("R6 push1", K_PSH, 0, 0, 0, 8'h25);
        step("R6 push2", K_PSH, 0, 0, 0, 8'h12);
        step("R6 push3", K_PSH, 0, 0, 0, 8'hF3);
        check("R6 sp", int'(sp), 8'h0A);
        rd_dir("R6 at08", 8'h08, 8'h25);
        rd_dir("R6 at0A", 8'h0A, 8'hF3);
        step("R7 pop", K_POP, 0, 0, 0, 0);
        check("R7 pop val", int'(rdata), 8'hF3);
        check("R7 pop sp", int'(sp), 8'h09);
        while (int'(sp) != 8'h7F) step("R6 fill", K_PSH, 0, 0, 0, int'(sp) + 1);
        step("R6 over", K_PSH, 0, 0, 0, 8'hDD);
        check("R6 over sp", int'(sp), 8'h80);
        step("R7 oor pop", K_POP, 0, 0, 0, 0);
        check("R7 oor zero", int'(rdata), 0);
        step("R7 top pop", K_POP, 0, 0, 0, 0);
        check("R7 top val", int'(rdata), 8'h7F);
        while (int'(sp) != 0) step("R7 drain", K_POP, 0, 0, 0, 0);
        step("R7 wrap", K_POP, 0, 0, 0, 0);
        check("R7 wrap sp", int'(sp), 8'hFF);

        // R9: random mix of every code
        for (int n = 0; n < 4000; n++)
            step("R9 random", int'($urandom_range(0, 15)), int'($urandom_range(0, 3)),
                 int'($urandom_range(0, 7)), int'($urandom_range(0, 127)),
                 int'($urandom_range(0, 255)));

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule